// File: doc/BRIEF.md
# Color Cursor Overlay and Palette

This block sits in the pixel path of a color display. It receives an 8-bit pixel code on every visible clock. It lays a 64x64 cursor image over the stream and looks up the result in a 1024-entry color table, which yields 8-bit red, green and blue values. Each cursor pixel holds a 2-bit code. That code becomes the top two bits of the table address, so it picks one of four quarters of the table, and the stream pixel picks the entry inside that quarter. Code 00 lands in the quarter that the normal image uses, so the cursor is transparent there. A solid-colored cursor shape is made by filling a whole quarter with one color.

The host loads the cursor image and the color table through one word-write port. Those writes take effect only while the vertical retrace input is high. The cursor position is double buffered: the host may write the pending X/Y pair at any time, and the active pair copies it only during vertical retrace. A horizontal down-counter is reloaded from the active X during every horizontal retrace and steps once per visible pixel. When it reaches zero, cursor columns start to flow. A line counter applies the same rule vertically, using the active Y. The output is registered, so it lags the input pixel by exactly one clock, and the blanking flag is delayed to match.

Top module: `curs_overlay_pal`

## Requirements
- R1: With wr_sel=0, a write stores wr_data[1:0] as the cursor code of row wr_addr[11:6], column wr_addr[5:0]. With wr_sel=1, a write stores wr_data as color entry wr_addr[9:0], with red in [23:16], green in [15:8] and blue in [7:0].
- R2: A write to either store while vretrace is low is ignored, and later pixels show the old contents.
- R3: The horizontal counter is loaded from the active X while hretrace is high and steps once per visible pixel (blank_in low). Visible pixel k of a line (counting from 0) is cursor column k-X when 0 <= k-X < 64.
- R4: Lines are counted from 0 at the first hretrace after a vertical retrace. Line L is cursor row L-Y when 0 <= L-Y < 64.
- R5: The color table address is {code, pix_in}. The code is the stored cursor code at (row, column) inside the window and 00 outside it, so code 00 leaves the pixel's own color.
- R6: red/green/blue one clock after a visible input pixel equal the table entry addressed by that pixel.
- R7: pos_wr loads the pending X/Y at any time. The active X/Y copy the pending values only while vretrace is high, so a write during a frame moves the cursor from the next frame on.
- R8: blank_out equals blank_in delayed by one clock, and red/green/blue are zero whenever blank_out is high.
- R9: While reset is held, blank_out is 1 and red/green/blue are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vretrace | input | 1 | Vertical retrace; enables writes and position transfer |
| hretrace | input | 1 | Horizontal retrace; reloads the horizontal counter, ends a line |
| blank_in | input | 1 | High on every non-visible clock |
| pix_in | input | 8 | Pixel code of the current visible pixel |
| wr_en | input | 1 | Store write strobe |
| wr_sel | input | 1 | Write target: 0 cursor image, 1 color table |
| wr_addr | input | 12 | Cursor {row, column} or color table index |
| wr_data | input | 24 | Cursor code in [1:0], or a packed color |
| pos_wr | input | 1 | Load the pending cursor position |
| pos_x | input | 11 | Pending horizontal position, in pixels |
| pos_y | input | 11 | Pending vertical position, in lines |
| red | output | 8 | Red output, registered |
| green | output | 8 | Green output, registered |
| blue | output | 8 | Blue output, registered |
| blank_out | output | 1 | Blanking aligned with the color outputs |

## Verification
The hardest case to reach from the ports is the gap between a position or store write and its visible effect. A position write made in the middle of a frame has to leave the rest of that frame untouched and then move the cursor in the next one. A write to the cursor image or color table outside retrace has to vanish without trace. The bench issues such writes during visible lines and aims them at the exact cursor code and color entry that a later pixel in the same frame reads. It then compares every output pixel of every frame against a model of the window arithmetic. The frames place the cursor at the origin, at an ordinary offset, and partly beyond the right and bottom edges, so the window is clipped on both axes.

// File: rtl/curs_pkg.sv
package curs_pkg;
  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_CLEAR = '0;

  typedef enum logic {
    TGT_CURSOR  = 1'b0,
    TGT_PALETTE = 1'b1
  } wtgt_e;
endpackage

// File: rtl/curs_posctl.sv
module curs_posctl #(
  parameter int CUR_DIM = 64,
  parameter int X_W = 11,
  parameter int Y_W = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        vretrace,
  input  logic                        hretrace,
  input  logic                        blank_in,
  input  logic                        pos_wr,
  input  logic [X_W-1:0]              pos_x,
  input  logic [Y_W-1:0]              pos_y,
  output logic                        in_win,
  output logic [$clog2(CUR_DIM)-1:0]  row_idx,
  output logic [$clog2(CUR_DIM)-1:0]  col_idx
);
  localparam int AW = $clog2(CUR_DIM);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DIM_C = CW'(CUR_DIM);

  logic [X_W-1:0] x_pend, x_act, hcnt;
  logic [Y_W-1:0] y_pend, y_act, vcnt;
  logic [CW-1:0]  col, row;
  logic           vfirst, hr_q;

  // named internal events
  logic hr_rise, pix_step, in_h, in_v;

  assign hr_rise  = hretrace && !hr_q;
  assign pix_step = !blank_in && !hretrace && !vretrace;

  // true while a down-counter has run out and the index is inside the window
  function automatic logic span_open(input logic cnt_zero, input logic [CW-1:0] idx);
    return cnt_zero && (idx < DIM_C);
  endfunction

  assign in_h    = span_open(hcnt == '0, col);
  assign in_v    = !vfirst && span_open(vcnt == '0, row);
  assign in_win  = pix_step && in_h && in_v;
  assign row_idx = row[AW-1:0];
  assign col_idx = col[AW-1:0];

  // position double buffer (R7)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_pend <= '0;
      y_pend <= '0;
      x_act  <= '0;
      y_act  <= '0;
    end else begin
      if (pos_wr) begin
        x_pend <= pos_x;
        y_pend <= pos_y;
      end
      if (vretrace) begin
        x_act <= x_pend;
        y_act <= y_pend;
      end
    end
  end

  // horizontal down-counter and column index (R3)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      col  <= DIM_C;
    end else if (hretrace) begin
      hcnt <= x_act;
      col  <= '0;
    end else if (pix_step) begin
      if (hcnt != '0)
        hcnt <= hcnt - 1'b1;
      else if (col != DIM_C)
        col <= col + 1'b1;
    end
  end

  // line counter and row index (R4)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr_q   <= 1'b0;
      vfirst <= 1'b1;
      vcnt   <= '0;
      row    <= '0;
    end else begin
      hr_q <= hretrace;
      if (vretrace) begin
        vfirst <= 1'b1;
      end else if (hr_rise) begin
        if (vfirst) begin
          vfirst <= 1'b0;
          vcnt   <= y_act;
          row    <= '0;
        end else if (vcnt != '0) begin
          vcnt <= vcnt - 1'b1;
        end else if (row != DIM_C) begin
          row <= row + 1'b1;
        end
      end
    end
  end

  assert_act_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vretrace |=> $stable(x_act) && $stable(y_act));

  assert_win_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (col < DIM_C) && (row < DIM_C));

  assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_win && $past(in_win) |-> col == CW'($past(col) + 1'b1));

  assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hretrace && !vretrace |=> $stable(row));
endmodule

// File: rtl/curs_store.sv
module curs_store #(
  parameter int CUR_DIM = 64,
  parameter int CODE_W = 2
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [2*$clog2(CUR_DIM)-1:0]  waddr,
  input  logic [CODE_W-1:0]             wcode,
  input  logic [2*$clog2(CUR_DIM)-1:0]  raddr,
  output logic [CODE_W-1:0]             rcode
);
  localparam int DEPTH = CUR_DIM * CUR_DIM;

  logic [CODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wcode;
  end

  assign rcode = mem[raddr];
endmodule

// File: rtl/curs_palette.sv
module curs_palette #(
  parameter int AW = 10,
  parameter int CHAN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [3*CHAN_W-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  input  logic                blank,
  output logic [3*CHAN_W-1:0] rgb,
  output logic                blank_q
);
  localparam int DEPTH = 1 << AW;

  logic [3*CHAN_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // one-clock registered output stage (R6, R8)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb     <= '0;
      blank_q <= 1'b1;
    end else begin
      blank_q <= blank;
      rgb     <= blank ? '0 : mem[raddr];
    end
  end

  assert_blank_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |-> rgb == '0);
endmodule

// File: rtl/curs_overlay_pal.sv
module curs_overlay_pal #(
  parameter int CUR_DIM = 64,
  parameter int PIX_W = 8,
  parameter int CHAN_W = 8,
  parameter int X_W = 11,
  parameter int Y_W = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          vretrace,
  input  logic                          hretrace,
  input  logic                          blank_in,
  input  logic [PIX_W-1:0]              pix_in,
  input  logic                          wr_en,
  input  logic                          wr_sel,
  input  logic [2*$clog2(CUR_DIM)-1:0]  wr_addr,
  input  logic [3*CHAN_W-1:0]           wr_data,
  input  logic                          pos_wr,
  input  logic [X_W-1:0]                pos_x,
  input  logic [Y_W-1:0]                pos_y,
  output logic [CHAN_W-1:0]             red,
  output logic [CHAN_W-1:0]             green,
  output logic [CHAN_W-1:0]             blue,
  output logic                          blank_out
);
  import curs_pkg::*;

  localparam int AW     = $clog2(CUR_DIM);
  localparam int PAL_AW = CODE_W + PIX_W;

  logic                  in_win;
  logic [AW-1:0]         row_idx, col_idx;
  logic [CODE_W-1:0]     cur_code, ovl_code;
  logic [PAL_AW-1:0]     pal_raddr;
  logic [3*CHAN_W-1:0]   rgb;
  logic                  cur_we, pal_we, blank_d;

  // writes land only during vertical retrace (R1, R2)
  function automatic logic write_ok(input logic en, input logic sel,
                                    input wtgt_e tgt, input logic vr);
    return en && vr && (sel == logic'(tgt));
  endfunction

  // table address from cursor code and pixel (R5)
  function automatic logic [PAL_AW-1:0] pal_index(input logic [CODE_W-1:0] code,
                                                  input logic [PIX_W-1:0] pix);
    return {code, pix};
  endfunction

  assign cur_we = write_ok(wr_en, wr_sel, TGT_CURSOR, vretrace);
  assign pal_we = write_ok(wr_en, wr_sel, TGT_PALETTE, vretrace);

  curs_posctl #(.CUR_DIM(CUR_DIM), .X_W(X_W), .Y_W(Y_W)) u_posctl (
    .clk(clk), .rst_n(rst_n), .vretrace(vretrace), .hretrace(hretrace),
    .blank_in(blank_in), .pos_wr(pos_wr), .pos_x(pos_x), .pos_y(pos_y),
    .in_win(in_win), .row_idx(row_idx), .col_idx(col_idx)
  );

  curs_store #(.CUR_DIM(CUR_DIM), .CODE_W(CODE_W)) u_store (
    .clk(clk), .we(cur_we), .waddr(wr_addr), .wcode(wr_data[CODE_W-1:0]),
    .raddr({row_idx, col_idx}), .rcode(cur_code)
  );

  assign ovl_code  = in_win ? cur_code : CODE_CLEAR;
  assign pal_raddr = pal_index(ovl_code, pix_in);

  curs_palette #(.AW(PAL_AW), .CHAN_W(CHAN_W)) u_palette (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .waddr(wr_addr[PAL_AW-1:0]),
    .wdata(wr_data), .raddr(pal_raddr), .blank(blank_in),
    .rgb(rgb), .blank_q(blank_d)
  );

  assign red       = rgb[3*CHAN_W-1:2*CHAN_W];
  assign green     = rgb[2*CHAN_W-1:CHAN_W];
  assign blue      = rgb[CHAN_W-1:0];
  assign blank_out = blank_d;

  assert_outside_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> pal_raddr[PAL_AW-1 -: CODE_W] == CODE_CLEAR);

  assert_blank_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blank_in |=> blank_out);
endmodule

// File: tb/curs_overlay_pal_bench.sv
module curs_overlay_pal_bench;
  localparam int W  = 80;
  localparam int NL = 70;
  localparam int D  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vretrace = 1'b0, hretrace = 1'b0, blank_in = 1'b1;
  logic [7:0] pix_in = '0;
  logic wr_en = 1'b0, wr_sel = 1'b0, pos_wr = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic [10:0] pos_x = '0, pos_y = '0;
  logic [7:0] red, green, blue;
  logic blank_out;

  always #10 clk = ~clk;

  curs_overlay_pal u_curs_overlay_pal (
    .clk(clk), .rst_n(rst_n), .vretrace(vretrace), .hretrace(hretrace),
    .blank_in(blank_in), .pix_in(pix_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .pos_wr(pos_wr), .pos_x(pos_x),
    .pos_y(pos_y), .red(red), .green(green), .blue(blue), .blank_out(blank_out)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [1:0]  cur_m [D*D];
  logic [23:0] pal_m [1024];

  bit have_exp = 1'b0;
  logic exp_bl;
  logic [23:0] exp_c;
  string exp_tag;

  function automatic logic [7:0] pix_of(int l, int k, int f);
    return 8'(l * 7 + k * 13 + f * 29);
  endfunction

  task automatic check_prev();
    if (have_exp) begin
      checks++;
      if (blank_out !== exp_bl || {red, green, blue} !== exp_c) begin
        failures++;
        $display("FAIL %s: got blank=%b rgb=%h exp blank=%b rgb=%h",
                 exp_tag, blank_out, {red, green, blue}, exp_bl, exp_c);
      end
    end
  endtask

  task automatic tick(input logic vr, hr, bl, input logic [7:0] px,
                      input logic we, ws, input logic [11:0] wa, input logic [23:0] wd,
                      input logic pw, input logic [10:0] nx, ny,
                      input logic e_bl, input logic [23:0] e_c, input string tag);
    @(negedge clk);
    check_prev();
    vretrace = vr; hretrace = hr; blank_in = bl; pix_in = px;
    wr_en = we; wr_sel = ws; wr_addr = wa; wr_data = wd;
    pos_wr = pw; pos_x = nx; pos_y = ny;
    have_exp = 1'b1; exp_bl = e_bl; exp_c = e_c; exp_tag = tag;
  endtask

  // vertical retrace: optional bulk load, position write, single cursor poke
  task automatic vret(input bit bulk, input bit pw, input logic [10:0] nx, ny, input bit poke);
    tick(1, 0, 1, 0, 0, 0, 0, 0, pw, nx, ny, 1, 0, "R8 vretrace");
    if (bulk) begin
      for (int a = 0; a < D * D; a++)
        tick(1, 0, 1, 0, 1, 0, 12'(a), 24'(cur_m[a]), 0, 0, 0, 1, 0, "R1 R8 load");
      for (int a = 0; a < 1024; a++)
        tick(1, 0, 1, 0, 1, 1, 12'(a), pal_m[a], 0, 0, 0, 1, 0, "R1 R8 load");
    end
    if (poke) begin
      cur_m[0] = 2'd2;
      tick(1, 0, 1, 0, 1, 0, 12'd0, 24'd2, 0, 0, 0, 1, 0, "R1 R8 poke");
    end
    for (int i = 0; i < 5; i++)
      tick(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 vretrace");
  endtask

  // one line: hretrace then W visible pixels; optional stray writes
  task automatic line(input int l, f, x, y, input string ftag,
                      input int stray_k, input int pw_k, input logic [10:0] nx, ny,
                      input logic [11:0] sa_c, input logic [9:0] sa_p);
    for (int i = 0; i < 4; i++)
      tick(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 hretrace");
    for (int k = 0; k < W; k++) begin
      logic [7:0] p;
      logic [1:0] code;
      bit inw;
      logic we, ws;
      logic [11:0] wa;
      logic [23:0] wd;
      string tag;
      p = pix_of(l, k, f);
      inw = (l >= y) && (l - y < D) && (k >= x) && (k - x < D);
      code = inw ? cur_m[(l - y) * D + (k - x)] : 2'b00;
      tag = inw ? {ftag, " R5 R6 inside"} : {ftag, " R5 R6 outside"};
      we = 0; ws = 0; wa = 0; wd = 0;
      if (k == stray_k) begin
        we = 1; ws = 0; wa = sa_c; wd = 24'(~cur_m[sa_c]);
      end
      if (k == stray_k + 1) begin
        we = 1; ws = 1; wa = 12'(sa_p); wd = ~pal_m[sa_p];
      end
      tick(0, 0, 0, p, we, ws, wa, wd, (k == pw_k), nx, ny, 0,
           pal_m[{code, p}], tag);
    end
  endtask

  task automatic frame(input int f, x, y, input string ftag,
                       input int stray_l, input int pw_l, input logic [10:0] nx, ny);
    for (int l = 0; l < NL; l++) begin
      // stray writes target the code and color used by line y, pixel x
      line(l, f, x, y, ftag, (l == stray_l) ? 20 : -5, (l == pw_l) ? 30 : -5, nx, ny,
           12'd0, {cur_m[0], pix_of(y, x, f)});
    end
  endtask

  initial begin
    for (int a = 0; a < D * D; a++) begin
      int r, c;
      r = a / D; c = a % D;
      cur_m[a] = 2'((r + 2 * c + (r >> 3)) & 3);
    end
    for (int a = 0; a < 1024; a++)
      pal_m[a] = {8'(a * 3 + 1), 8'(a >> 2), 8'(a ^ 'h0A5)};

    repeat (3) @(negedge clk);
    checks++;
    if (blank_out !== 1'b1 || {red, green, blue} !== 24'h0) begin
      failures++;
      $display("FAIL R9 reset: got blank=%b rgb=%h exp blank=1 rgb=000000",
               blank_out, {red, green, blue});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // frame 0: bulk load, cursor at (5,3)
    vret(1, 1, 11'd5, 11'd3, 0);
    frame(0, 5, 3, "R1 R3 R4", -1, -1, 0, 0);
    // frame 1: mid-frame position write and stray store writes must not show
    vret(0, 0, 0, 0, 0);
    frame(1, 5, 3, "R2 R7", 1, 2, 11'd0, 11'd0);
    // frame 2: new position at origin, one legal cursor write in retrace
    vret(0, 0, 0, 0, 1);
    frame(2, 0, 0, "R1 R3 R4 R7", -1, 5, 11'd70, 11'd40);
    // frame 3: window clipped on the right and bottom
    vret(0, 0, 0, 0, 0);
    frame(3, 70, 40, "R3 R4 clip", -1, -1, 0, 0);
    vret(0, 0, 0, 0, 0);
    @(negedge clk);
    check_prev();

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule